// File: doc/BRIEF.md
# Cascadable Column Data Loader

This block is the digital front end of a display column driver. The controller starts each line with a start pulse that lasts one clock. On that edge and on each of the next edges, the block captures one 36-bit word (six 6-bit gray codes, two pixels) into the next capture slot of its line register. A slot pointer driven by a counter walks across the slots in the selected direction. When the last slot fills, the block sends a one-clock carry pulse out of the far end of the chain, and that pulse starts the next driver in the cascade. Two clocks later the block halts by itself. It accepts nothing more until a rising edge on the line strobe clears it for the next line.

The shift direction picks which start pin is the input, which carry pin is the output and which way the slots fill. A mode input either uses all slots or skips a group of slots in the middle, which shortens the chain. Two inversion inputs complement the lower or the upper half of each word as it is captured. In a board-level wrapper, `dirRight` should be tied high and `fullMode` tied low when they are left undriven. The whole line register leaves the block as one flat vector, which feeds the downstream line latch.

Top module: `column_loader`

## Requirements
- R1: Each load edge writes the 36-bit word into exactly one slot of `lineData`. Slot s occupies bits [36*s+35 : 36*s]. Each 6-bit code has its LSB at its lowest bit. Slots not addressed keep their value.
- R2: When `invLo` is high on a load edge, bits [17:0] of the stored word are the complement of the input. When `invHi` is high, bits [35:18] are complemented. Both inputs are sampled on the same edge as the word.
- R3: With `dirRight` high, the line starts from `loStartIn`, slots fill from slot 0 upward, and the carry appears on `hiCarryOut`. With `dirRight` low, the line starts from `hiStartIn`, slots fill from slot SLOTS-1 downward, and the carry appears on `loCarryOut`. The unselected carry output stays low.
- R4: A line starts on the first edge where the selected start input is sampled high, and that edge loads the first slot. A start held high for extra clocks, or raised again while the line is running, has no effect.
- R5: The carry output goes high right after the edge that loads the last slot, which is the Nth load edge counting the start edge. It stays high for exactly one clock.
- R6: After N+2 edges counting the start edge, the block halts. Later words and start pulses do not change `lineData` until the line strobe has risen.
- R7: A rising edge of `lineStrobe` stops a line in progress, and no slot is written on that edge or after it. The next start pulse then begins a new line.
- R8: With `fullMode` high, N = SLOTS. With it low, N = SLOTS-SKIP, and the SKIP slots starting at index (SLOTS-SKIP)/2 are skipped in both directions and never written.
- R9: After reset, `lineData` is all zero and both carry outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock; everything is sampled on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| dirRight | input | 1 | High: fill upward from slot 0; low: fill downward |
| fullMode | input | 1 | High: all slots; low: middle slots skipped |
| loStartIn | input | 1 | Start pulse input at the low-slot end (used when dirRight is high) |
| hiStartIn | input | 1 | Start pulse input at the high-slot end (used when dirRight is low) |
| lineStrobe | input | 1 | Line strobe; its rising edge clears the loader |
| wordIn | input | 36 | Six 6-bit gray codes |
| invLo | input | 1 | Complement bits [17:0] of the captured word |
| invHi | input | 1 | Complement bits [35:18] of the captured word |
| loCarryOut | output | 1 | Carry pulse to the next chip when filling downward |
| hiCarryOut | output | 1 | Carry pulse to the next chip when filling upward |
| lineData | output | SLOTS*36 | Flat line register, slot s at bits [36*s+35:36*s] |

## Verification
The lines are loaded with random words in all four combinations of direction and channel mode. The fixed slot maps of these combinations tell a reversed fill order apart from a mis-skipped middle group. Inversion is tried off, lower half only, upper half only and random per word, which separates a swapped half mask from a missing one. Directed lines hold the start pulse high for several clocks and raise it again mid-line. After the halt, more words and start pulses are fed in, and this exposes any load outside the window. One line is cut short by the strobe after three words, and the carry is sampled one clock early, on its edge and one clock late.

// File: rtl/column_loader_pkg.sv
package column_loader_pkg;
  localparam int CODE_W  = 6;
  localparam int CODES   = 6;
  localparam int WORD_W  = CODE_W * CODES;
  localparam int HALF_W  = WORD_W / 2;
  localparam int SLOT_W  = 10;

  typedef struct packed {
    logic              loadEn;
    logic [SLOT_W-1:0] slot;
  } loadCtl_t;
endpackage

// File: rtl/column_loader_ctrl.sv
module column_loader_ctrl
  import column_loader_pkg::*;
#(
  parameter int SLOTS = 16,
  parameter int SKIP  = 2
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     dirRight,
  input  logic     fullMode,
  input  logic     loStartIn,
  input  logic     hiStartIn,
  input  logic     lineStrobe,
  output loadCtl_t ctl,
  output logic     loCarryOut,
  output logic     hiCarryOut
);
  localparam int SKIP_LO = (SLOTS - SKIP) / 2;
  localparam int CW      = $clog2(SLOTS + 3);

  typedef enum logic [1:0] {IDLE, RUN, DONE} phase_t;

  phase_t phase, phaseNext;
  logic [CW-1:0] cnt, cntNext, activeN, idx;
  logic strobePrev, strobeRise, startIn, loadNow, lastLoad;
  logic carryQ, carryDirQ;
  int ascSlot, physSlot;

  assign strobeRise = lineStrobe & ~strobePrev;
  assign startIn    = dirRight ? loStartIn : hiStartIn;
  assign activeN    = fullMode ? CW'(SLOTS) : CW'(SLOTS - SKIP);

  always_comb begin
    phaseNext = phase;
    cntNext   = cnt;
    loadNow   = 1'b0;
    idx       = cnt;
    if (strobeRise) begin
      phaseNext = IDLE;
      cntNext   = '0;
    end else begin
      case (phase)
        IDLE: if (startIn) begin
          loadNow   = 1'b1;
          idx       = '0;
          phaseNext = RUN;
          cntNext   = CW'(1);
        end
        RUN: begin
          loadNow = (cnt < activeN);
          cntNext = cnt + CW'(1);
          if (cnt == activeN + CW'(1)) phaseNext = DONE;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    ascSlot = int'(idx);
    if (!fullMode && ascSlot >= SKIP_LO) ascSlot = ascSlot + SKIP;
    physSlot = dirRight ? ascSlot : (SLOTS - 1 - ascSlot);
  end

  assign lastLoad   = loadNow && (idx == activeN - CW'(1));
  assign ctl.loadEn = loadNow;
  assign ctl.slot   = SLOT_W'(physSlot);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase      <= IDLE;
      cnt        <= '0;
      strobePrev <= 1'b0;
      carryQ     <= 1'b0;
      carryDirQ  <= 1'b0;
    end else begin
      phase      <= phaseNext;
      cnt        <= cntNext;
      strobePrev <= lineStrobe;
      carryQ     <= lastLoad;
      if (lastLoad) carryDirQ <= dirRight;
    end
  end

  assign hiCarryOut = carryQ & carryDirQ;
  assign loCarryOut = carryQ & ~carryDirQ;
endmodule

// File: rtl/column_loader_dp.sv
module column_loader_dp
  import column_loader_pkg::*;
#(
  parameter int SLOTS = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  loadCtl_t                ctl,
  input  logic [WORD_W-1:0]       wordIn,
  input  logic                    invLo,
  input  logic                    invHi,
  output logic [SLOTS*WORD_W-1:0] lineData
);
  logic [WORD_W-1:0] fixedWord;

  assign fixedWord = wordIn ^ {{HALF_W{invHi}}, {HALF_W{invLo}}};

  for (genvar s = 0; s < SLOTS; s++) begin : gSlot
    logic [WORD_W-1:0] slotQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) slotQ <= '0;
      else if (ctl.loadEn && ctl.slot == SLOT_W'(s)) slotQ <= fixedWord;
    end
    assign lineData[s*WORD_W +: WORD_W] = slotQ;
  end
endmodule

// File: rtl/column_loader.sv
module column_loader
  import column_loader_pkg::*;
#(
  parameter int SLOTS = 16,
  parameter int SKIP  = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    dirRight,
  input  logic                    fullMode,
  input  logic                    loStartIn,
  input  logic                    hiStartIn,
  input  logic                    lineStrobe,
  input  logic [35:0]             wordIn,
  input  logic                    invLo,
  input  logic                    invHi,
  output logic                    loCarryOut,
  output logic                    hiCarryOut,
  output logic [SLOTS*36-1:0]     lineData
);
  loadCtl_t ctlBus;

  column_loader_ctrl #(.SLOTS(SLOTS), .SKIP(SKIP)) uCtrl (
    .clk(clk), .rstN(rstN), .dirRight(dirRight), .fullMode(fullMode),
    .loStartIn(loStartIn), .hiStartIn(hiStartIn), .lineStrobe(lineStrobe),
    .ctl(ctlBus), .loCarryOut(loCarryOut), .hiCarryOut(hiCarryOut)
  );

  column_loader_dp #(.SLOTS(SLOTS)) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctlBus), .wordIn(wordIn),
    .invLo(invLo), .invHi(invHi), .lineData(lineData)
  );
endmodule

// File: rtl/column_loader_chk.sv
module column_loader_chk
  import column_loader_pkg::*;
#(
  parameter int SLOTS = 16,
  parameter int SKIP  = 2
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    fullMode,
  input logic                    lineStrobe,
  input loadCtl_t                ctlBus,
  input logic [WORD_W-1:0]       wordIn,
  input logic                    invLo,
  input logic                    invHi,
  input logic                    loCarryOut,
  input logic                    hiCarryOut,
  input logic [SLOTS*WORD_W-1:0] lineData
);
  localparam int SKIP_LO = (SLOTS - SKIP) / 2;

  logic              prevEn;
  logic [SLOT_W-1:0] prevSlot;
  logic [WORD_W-1:0] prevWord;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevEn   <= 1'b0;
      prevSlot <= '0;
      prevWord <= '0;
    end else begin
      prevEn   <= ctlBus.loadEn;
      prevSlot <= ctlBus.slot;
      prevWord <= wordIn ^ {{HALF_W{invHi}}, {HALF_W{invLo}}};
    end
  end

  a_r1_word_lands: assert property (@(posedge clk) disable iff (!rstN)
    prevEn |-> (lineData[int'(prevSlot)*WORD_W +: WORD_W] == prevWord));

  a_r3_one_carry_pin: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({loCarryOut, hiCarryOut}));

  a_r5_carry_single: assert property (@(posedge clk) disable iff (!rstN)
    (loCarryOut || hiCarryOut) |=> !(loCarryOut || hiCarryOut));

  a_r7_strobe_blocks: assert property (@(posedge clk) disable iff (!rstN)
    (lineStrobe && !$past(lineStrobe)) |-> !ctlBus.loadEn);

  a_r8_skip_untouched: assert property (@(posedge clk) disable iff (!rstN)
    (ctlBus.loadEn && !fullMode) |->
      !(int'(ctlBus.slot) >= SKIP_LO && int'(ctlBus.slot) < SKIP_LO + SKIP));
endmodule

bind column_loader column_loader_chk #(.SLOTS(SLOTS), .SKIP(SKIP)) uChk (
  .clk(clk), .rstN(rstN), .fullMode(fullMode), .lineStrobe(lineStrobe),
  .ctlBus(ctlBus), .wordIn(wordIn), .invLo(invLo), .invHi(invHi),
  .loCarryOut(loCarryOut), .hiCarryOut(hiCarryOut), .lineData(lineData)
);

// File: tb/tb_column_loader.sv
`timescale 1ns/100ps
module tb_column_loader;
  localparam int SLOTS   = 16;
  localparam int SKIP    = 2;
  localparam int SKIP_LO = (SLOTS - SKIP) / 2;
  localparam int W       = 36;

  logic clk = 1'b0;
  logic rstN, dirRight, fullMode, loStartIn, hiStartIn, lineStrobe, invLo, invHi;
  logic [W-1:0] wordIn;
  logic loCarryOut, hiCarryOut;
  logic [SLOTS*W-1:0] lineData;

  int total = 0;
  int bad   = 0;
  logic [W-1:0] expSlot [SLOTS];

  always #2.5 clk = ~clk;

  column_loader #(.SLOTS(SLOTS), .SKIP(SKIP)) dut (
    .clk(clk), .rstN(rstN), .dirRight(dirRight), .fullMode(fullMode),
    .loStartIn(loStartIn), .hiStartIn(hiStartIn), .lineStrobe(lineStrobe),
    .wordIn(wordIn), .invLo(invLo), .invHi(invHi),
    .loCarryOut(loCarryOut), .hiCarryOut(hiCarryOut), .lineData(lineData)
  );

  function automatic int slotOf(int i, bit dir, bit full);
    int a = i;
    if (!full && a >= SKIP_LO) a = a + SKIP;
    return dir ? a : SLOTS - 1 - a;
  endfunction

  function automatic logic [W-1:0] invWord(logic [W-1:0] w, bit lo, bit hi);
    return w ^ {{18{hi}}, {18{lo}}};
  endfunction

  function automatic logic [SLOTS*W-1:0] expFlat();
    logic [SLOTS*W-1:0] f;
    for (int s = 0; s < SLOTS; s++) f[s*W +: W] = expSlot[s];
    return f;
  endfunction

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic checkBit(string tag, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic checkLine(string tag);
    logic [SLOTS*W-1:0] e = expFlat();
    total++;
    if (lineData !== e) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, lineData, e);
    end
  endtask

  task automatic driveStart(bit dir, bit s);
    loStartIn = dir ? s : 1'b0;
    hiStartIn = dir ? 1'b0 : s;
  endtask

  // invMode: 0 none, 1 lower half, 2 upper half, 3 random per word
  task automatic runLine(bit dir, bit full, int startLen, bit midStart, int invMode, string tag);
    int n = full ? SLOTS : SLOTS - SKIP;
    dirRight = dir;
    fullMode = full;
    for (int i = 0; i < n; i++) begin
      logic [W-1:0] w = W'({$urandom, $urandom});
      bit lo = (invMode == 1) || (invMode == 3 && $urandom_range(1, 0) == 1);
      bit hi = (invMode == 2) || (invMode == 3 && $urandom_range(1, 0) == 1);
      wordIn = w; invLo = lo; invHi = hi;
      driveStart(dir, (i < startLen) || (midStart && i == n / 2));
      expSlot[slotOf(i, dir, full)] = invWord(w, lo, hi);
      if (i == n - 1) checkBit({tag, " R5 carry early"}, loCarryOut | hiCarryOut, 1'b0);
      step();
    end
    driveStart(dir, 1'b0);
    checkBit({tag, " R5 R3 carry on far pin"}, dir ? hiCarryOut : loCarryOut, 1'b1);
    checkBit({tag, " R3 near pin quiet"}, dir ? loCarryOut : hiCarryOut, 1'b0);
    wordIn = W'({$urandom, $urandom});
    step();
    checkBit({tag, " R5 carry one clock"}, loCarryOut | hiCarryOut, 1'b0);
    step();
    for (int k = 0; k < 3; k++) begin
      wordIn = W'({$urandom, $urandom});
      driveStart(dir, k != 1);
      step();
    end
    driveStart(dir, 1'b0);
    checkLine({tag, " R1 R2 R4 R6 R8 line content after halt"});
    lineStrobe = 1'b1; step(); step();
    lineStrobe = 1'b0; step();
  endtask

  initial begin
    #(150000 * 5);
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h1d2c3b4a));
    for (int s = 0; s < SLOTS; s++) expSlot[s] = '0;
    rstN = 1'b0; dirRight = 1'b1; fullMode = 1'b0;
    loStartIn = 1'b0; hiStartIn = 1'b0; lineStrobe = 1'b0;
    invLo = 1'b0; invHi = 1'b0; wordIn = '0;
    repeat (3) step();
    rstN = 1'b1;
    step();
    checkLine("R9 reset data");
    checkBit("R9 reset carry", loCarryOut | hiCarryOut, 1'b0);

    runLine(1'b1, 1'b1, 1, 1'b0, 0, "R3 right full");
    runLine(1'b0, 1'b1, 1, 1'b0, 1, "R2 left full invLo");
    runLine(1'b1, 1'b0, 1, 1'b0, 2, "R8 right reduced invHi");
    runLine(1'b0, 1'b0, 3, 1'b1, 3, "R4 left reduced long start");

    // R7: strobe cuts a right full line after three words
    dirRight = 1'b1; fullMode = 1'b1;
    for (int i = 0; i < 3; i++) begin
      logic [W-1:0] w = W'({$urandom, $urandom});
      wordIn = w; invLo = 1'b0; invHi = 1'b0;
      driveStart(1'b1, i == 0);
      expSlot[slotOf(i, 1'b1, 1'b1)] = w;
      step();
    end
    driveStart(1'b1, 1'b0);
    lineStrobe = 1'b1;
    wordIn = W'({$urandom, $urandom});
    step(); step();
    lineStrobe = 1'b0;
    for (int k = 0; k < 4; k++) begin
      wordIn = W'({$urandom, $urandom});
      step();
    end
    checkLine("R7 strobe stops loading");
    checkBit("R7 no carry after abort", loCarryOut | hiCarryOut, 1'b0);
    runLine(1'b1, 1'b1, 1, 1'b0, 3, "R7 restart after strobe");

    for (int r = 0; r < 8; r++) begin
      runLine(1'($urandom_range(1, 0)), 1'($urandom_range(1, 0)),
              $urandom_range(2, 1), 1'($urandom_range(1, 0)), 3, "R1 random line");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule